// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the time of day for packet timestamping. On every cycle of its dedicated timestamp clock the time advances by a programmable whole-nanosecond step plus a programmable 24-bit binary fraction of a nanosecond. For a timestamp clock of frequency F, software sets the whole step to the integer part of 1e9/F and the fraction to the remainder scaled by 2^24. The time is held as 48 bits of seconds, 30 bits of nanoseconds and 24 bits of sub-nanosecond fraction.

A simple word-wide register port lets software load an absolute time, read the current time as one coherent value across several words, apply a signed offset of less than one second in a single update, and rewrite the step to trim the frequency. For each traffic direction a strobe input captures a compact stamp (nanoseconds plus the low five seconds bits) and, alongside it, the full seconds value.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds, fraction and both step registers are zero, so the time stays at zero until software writes a non-zero step; reading address 4 or 5 after reset returns 0.
- R2: On each clock cycle without a load or an accepted offset, the fraction gains the fractional step (address 5, bits 23:0) modulo 2^24 and the nanoseconds gain the whole step (address 4) plus one when the fraction sum carries out of bit 23.
- R3: When the nanosecond sum reaches or passes 1,000,000,000 it is reduced by 1,000,000,000 and the 48-bit seconds value increments, carrying across bit 31; nanoseconds never hold a value of 1e9 or more.
- R4: A load writes the seconds upper 16 bits to address 0 and lower 32 bits to address 1 as staging values, then a write to address 2 (bits 29:0 = nanoseconds) commits seconds and nanoseconds, clears the fraction and replaces that cycle's step; a value of 1e9 or more written to address 2 is ignored.
- R5: A write to address 6 applies an offset: bit 31 set means subtract, bits 29:0 give the magnitude in nanoseconds. An addition past 1e9 carries one second; a subtraction below zero borrows one second and adds 1e9. The fraction is untouched and that cycle's step is dropped.
- R6: An offset with magnitude of 1e9 or more is rejected: the time only takes its normal step, and the adj_reject output is high for exactly the one cycle after the write.
- R7: A write to address 4 or 5 takes effect from the following cycle; the step in the write cycle still uses the old value.
- R8: rd_data presents, one cycle after rd_en, the addressed word. Reading address 1 returns the live seconds low word and snapshots the seconds upper bits, nanoseconds and fraction; addresses 0, 2 and 3 then return those snapshots unchanged however long the counter runs.
- R9: A pulse on evt_strobe[d] latches, for direction d, the stamp {seconds[4:0], nanoseconds} at cap_stamp[d*35 +: 35] and the full seconds at cap_sec[d*48 +: 48], using the time held before that edge; cap_valid[d] is high the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| adj_reject | output | 1 | One-cycle pulse when an offset is refused |
| evt_strobe | input | NDIR | Per-direction capture strobes |
| cap_stamp | output | NDIR*35 | Per-direction compact stamps |
| cap_sec | output | NDIR*48 | Per-direction full seconds at capture |
| cap_valid | output | NDIR | Per-direction capture valid pulse |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
On every cycle the assertions check that nanoseconds stay below one second, that seconds never move by more than one without a load or offset, that a zero step freezes the time, that loads clear the fraction, that offsets leave the fraction alone, that refused offsets raise the reject pulse and that captures record the prior time. Only the bench scenarios show exact arithmetic: fraction carries over several cycles, carries into the upper seconds word, borrow on negative offsets, the one-cycle delay of a new step, and that snapshot reads stay frozen while the counter runs.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W   = 48;
  localparam int NS_W    = 30;
  localparam int FRAC_W  = 24;
  localparam int SEC_HI_W = SEC_W - 32;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  typedef enum logic [2:0] {
    REG_SEC_HI   = 3'd0,
    REG_SEC_LO   = 3'd1,
    REG_NSEC     = 3'd2,
    REG_FRAC     = 3'd3,
    REG_INC_NS   = 3'd4,
    REG_INC_FRAC = 3'd5,
    REG_OFFSET   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;
endpackage

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
#(
  parameter int INC_NS_W = 8
) (
  input  tod_t                cur,
  input  logic [INC_NS_W-1:0] inc_ns,
  input  logic [FRAC_W-1:0]   inc_frac,
  output tod_t                nxt
);
  logic [FRAC_W:0] frac_sum;
  logic [NS_W:0]   ns_sum;

  always_comb begin
    frac_sum = {1'b0, cur.frac} + {1'b0, inc_frac};
    ns_sum   = {1'b0, cur.ns} + (NS_W+1)'(inc_ns) + (NS_W+1)'(frac_sum[FRAC_W]);
    nxt.frac = frac_sum[FRAC_W-1:0];
    if (ns_sum >= {1'b0, NS_PER_SEC}) begin
      nxt.ns  = NS_W'(ns_sum - {1'b0, NS_PER_SEC});
      nxt.sec = cur.sec + SEC_W'(1);
    end else begin
      nxt.ns  = ns_sum[NS_W-1:0];
      nxt.sec = cur.sec;
    end
  end
endmodule

// File: rtl/tod_offset.sv
module tod_offset
  import tod_pkg::*;
(
  input  tod_t            cur,
  input  logic            sub,
  input  logic [NS_W-1:0] mag,
  output tod_t            nxt,
  output logic            bad
);
  logic [NS_W:0] up_sum;
  logic [NS_W:0] wrap_sum;

  always_comb begin
    bad      = (mag >= NS_PER_SEC);
    up_sum   = {1'b0, cur.ns} + {1'b0, mag};
    wrap_sum = {1'b0, cur.ns} + {1'b0, NS_PER_SEC} - {1'b0, mag};
    nxt.frac = cur.frac;
    nxt.sec  = cur.sec;
    nxt.ns   = cur.ns;
    if (!sub) begin
      if (up_sum >= {1'b0, NS_PER_SEC}) begin
        nxt.ns  = NS_W'(up_sum - {1'b0, NS_PER_SEC});
        nxt.sec = cur.sec + SEC_W'(1);
      end else begin
        nxt.ns  = up_sum[NS_W-1:0];
      end
    end else begin
      if (cur.ns >= mag) begin
        nxt.ns  = cur.ns - mag;
      end else begin
        nxt.ns  = wrap_sum[NS_W-1:0];
        nxt.sec = cur.sec - SEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import tod_pkg::*;
#(
  parameter int LOW_SEC_W = 5,
  localparam int STAMP_W = LOW_SEC_W + NS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [SEC_W-1:0]   sec,
  input  logic [NS_W-1:0]    ns,
  output logic [STAMP_W-1:0] stamp,
  output logic [SEC_W-1:0]   sec_full,
  output logic               valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp    <= '0;
      sec_full <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= strobe;
      if (strobe) begin
        stamp    <= {sec[LOW_SEC_W-1:0], ns};
        sec_full <= sec;
      end
    end
  end

  // R9: capture records the time presented before the strobe edge
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (valid && stamp[NS_W-1:0] == $past(ns) && sec_full == $past(sec)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int NDIR      = 2,
  parameter int INC_NS_W  = 8,
  parameter int LOW_SEC_W = 5,
  localparam int STAMP_W  = LOW_SEC_W + NS_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [31:0]             wr_data,
  input  logic                    rd_en,
  input  logic [2:0]              rd_addr,
  output logic [31:0]             rd_data,
  output logic                    adj_reject,
  input  logic [NDIR-1:0]         evt_strobe,
  output logic [NDIR*STAMP_W-1:0] cap_stamp,
  output logic [NDIR*SEC_W-1:0]   cap_sec,
  output logic [NDIR-1:0]         cap_valid,
  output logic [SEC_W-1:0]        tod_sec,
  output logic [NS_W-1:0]         tod_ns
);
  tod_t                tod_q, tod_d, step_nxt, off_nxt;
  logic [INC_NS_W-1:0] inc_ns_q;
  logic [FRAC_W-1:0]   inc_frac_q;
  logic [SEC_HI_W-1:0] stage_hi_q;
  logic [31:0]         stage_lo_q;
  logic [SEC_HI_W-1:0] snap_hi_q;
  logic [NS_W-1:0]     snap_ns_q;
  logic [FRAC_W-1:0]   snap_frac_q;
  logic [31:0]         rd_q;
  logic                reject_q;

  logic            load_req, adj_req, adj_bad, adj_apply;
  logic [NS_W-1:0] adj_mag;

  tod_step #(.INC_NS_W(INC_NS_W)) u_step (
    .cur(tod_q), .inc_ns(inc_ns_q), .inc_frac(inc_frac_q), .nxt(step_nxt)
  );

  tod_offset u_offset (
    .cur(tod_q), .sub(wr_data[31]), .mag(adj_mag), .nxt(off_nxt), .bad(adj_bad)
  );

  always_comb begin
    adj_mag   = wr_data[NS_W-1:0];
    load_req  = wr_en && (wr_addr == REG_NSEC) && (wr_data[NS_W-1:0] < NS_PER_SEC);
    adj_req   = wr_en && (wr_addr == REG_OFFSET);
    adj_apply = adj_req && !adj_bad;
    if (load_req) begin
      tod_d.sec  = {stage_hi_q, stage_lo_q};
      tod_d.ns   = wr_data[NS_W-1:0];
      tod_d.frac = '0;
    end else if (adj_apply) begin
      tod_d = off_nxt;
    end else begin
      tod_d = step_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q       <= '0;
      inc_ns_q    <= '0;
      inc_frac_q  <= '0;
      stage_hi_q  <= '0;
      stage_lo_q  <= '0;
      reject_q    <= 1'b0;
    end else begin
      tod_q    <= tod_d;
      reject_q <= adj_req && adj_bad;
      if (wr_en) begin
        case (wr_addr)
          REG_SEC_HI:   stage_hi_q <= wr_data[SEC_HI_W-1:0];
          REG_SEC_LO:   stage_lo_q <= wr_data;
          REG_INC_NS:   inc_ns_q   <= wr_data[INC_NS_W-1:0];
          REG_INC_FRAC: inc_frac_q <= wr_data[FRAC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_hi_q   <= '0;
      snap_ns_q   <= '0;
      snap_frac_q <= '0;
      rd_q        <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        REG_SEC_HI:   rd_q <= 32'(snap_hi_q);
        REG_SEC_LO: begin
          rd_q        <= tod_q.sec[31:0];
          snap_hi_q   <= tod_q.sec[SEC_W-1:32];
          snap_ns_q   <= tod_q.ns;
          snap_frac_q <= tod_q.frac;
        end
        REG_NSEC:     rd_q <= 32'(snap_ns_q);
        REG_FRAC:     rd_q <= 32'(snap_frac_q);
        REG_INC_NS:   rd_q <= 32'(inc_ns_q);
        REG_INC_FRAC: rd_q <= 32'(inc_frac_q);
        default:      rd_q <= '0;
      endcase
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_cap
    tod_capture #(.LOW_SEC_W(LOW_SEC_W)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .strobe   (evt_strobe[d]),
      .sec      (tod_q.sec),
      .ns       (tod_q.ns),
      .stamp    (cap_stamp[d*STAMP_W +: STAMP_W]),
      .sec_full (cap_sec[d*SEC_W +: SEC_W]),
      .valid    (cap_valid[d])
    );
  end

  assign rd_data    = rd_q;
  assign adj_reject = reject_q;
  assign tod_sec    = tod_q.sec;
  assign tod_ns     = tod_q.ns;

  // R1: with a zero step and no write to the time, the time holds
  a_r1_stopped: assert property (@(posedge clk) disable iff (rst)
    (inc_ns_q == '0 && inc_frac_q == '0 && !load_req && !adj_apply) |=> $stable(tod_q));

  // R3: nanoseconds stay below one second
  a_r3_ns_range: assert property (@(posedge clk) disable iff (rst)
    tod_q.ns < NS_PER_SEC);

  // R3: a plain step moves seconds by at most one
  a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
    (!load_req && !adj_apply) |=>
      (tod_q.sec == $past(tod_q.sec) || tod_q.sec == $past(tod_q.sec) + SEC_W'(1)));

  // R4: a load clears the fraction
  a_r4_load_frac: assert property (@(posedge clk) disable iff (rst)
    load_req |=> tod_q.frac == '0);

  // R5: an accepted offset leaves the fraction untouched
  a_r5_frac_kept: assert property (@(posedge clk) disable iff (rst)
    adj_apply |=> tod_q.frac == $past(tod_q.frac));

  // R6: an oversized offset raises the reject pulse
  a_r6_reject: assert property (@(posedge clk) disable iff (rst)
    (adj_req && wr_data[NS_W-1:0] >= NS_PER_SEC) |=> adj_reject);
endmodule

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
  localparam int NDIR = 2;
  localparam int SW = 35;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        adj_reject;
  logic [NDIR-1:0]    evt_strobe = '0;
  logic [NDIR*SW-1:0] cap_stamp;
  logic [NDIR*48-1:0] cap_sec;
  logic [NDIR-1:0]    cap_valid;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tod_clock u_tod_clock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .adj_reject(adj_reject),
    .evt_strobe(evt_strobe), .cap_stamp(cap_stamp), .cap_sec(cap_sec),
    .cap_valid(cap_valid), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  typedef struct packed {
    logic [7:0]  inc_ns;
    logic [23:0] inc_frac;
    logic [47:0] sec;
    logic [29:0] ns;
    logic [15:0] cycles;
    logic [47:0] exp_sec;
    logic [29:0] exp_ns;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd8,  24'h000000, 48'd5,            30'd100,         16'd10, 48'd5,            30'd180},
    '{8'd8,  24'h800000, 48'd0,            30'd0,           16'd10, 48'd0,            30'd85},
    '{8'd8,  24'h000000, 48'd7,            30'd999_999_990, 16'd3,  48'd8,            30'd14},
    '{8'd40, 24'h400000, 48'h0_FFFF_FFFF,  30'd999_999_950, 16'd2,  48'h1_0000_0000,  30'd30},
    '{8'd0,  24'h000000, 48'd3,            30'd42,          16'd20, 48'd3,            30'd42},
    '{8'd6,  24'hAAAAAB, 48'd1,            30'd0,           16'd3,  48'd1,            30'd20}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load(input logic [47:0] s, input logic [29:0] n);
    wr(3'd0, 32'(s[47:32]));
    wr(3'd1, s[31:0]);
    wr(3'd2, 32'(n));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [29:0] v_ns;
    logic [47:0] v_sec;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and stopped counter
    check("R1 sec", 64'(tod_sec), 64'd0);
    check("R1 ns", 64'(tod_ns), 64'd0);
    repeat (5) @(negedge clk);
    check("R1 still", 64'(tod_ns), 64'd0);
    rd(3'd4, r); check("R1 inc_ns", 64'(r), 64'd0);
    rd(3'd5, r); check("R1 inc_frac", 64'(r), 64'd0);

    // R2 R3 R4: vector walk
    for (int i = 0; i < 6; i++) begin
      wr(3'd4, 32'(VECS[i].inc_ns));
      wr(3'd5, 32'(VECS[i].inc_frac));
      load(VECS[i].sec, VECS[i].ns);
      check("R4 load ns", 64'(tod_ns), 64'(VECS[i].ns));
      for (int k = 0; k < int'(VECS[i].cycles); k++) @(negedge clk);
      check("R2/R3 sec", 64'(tod_sec), 64'(VECS[i].exp_sec));
      check("R2/R3 ns", 64'(tod_ns), 64'(VECS[i].exp_ns));
    end

    // R7: new step from the next cycle
    wr(3'd5, 32'd0);
    wr(3'd4, 32'd10);
    load(48'd2, 30'd0);
    wr(3'd4, 32'd3);
    check("R7 old step", 64'(tod_ns), 64'd10);
    @(negedge clk);
    check("R7 new step", 64'(tod_ns), 64'd13);

    // R5: offset replaces the step in its cycle
    wr(3'd6, 32'd5);
    check("R5 step dropped", 64'(tod_ns), 64'd18);
    @(negedge clk);
    check("R5 step resumes", 64'(tod_ns), 64'd21);

    // R5: carry and borrow with a stopped counter
    wr(3'd4, 32'd0);
    load(48'd10, 30'd500);
    wr(3'd6, 32'd999_999_600);
    check("R5 carry sec", 64'(tod_sec), 64'd11);
    check("R5 carry ns", 64'(tod_ns), 64'd100);
    wr(3'd6, 32'h8000_0000 | 32'd800);
    check("R5 borrow sec", 64'(tod_sec), 64'd10);
    check("R5 borrow ns", 64'(tod_ns), 64'd999_999_300);

    // R6: oversized offset refused
    wr(3'd6, 32'd1_000_000_000);
    check("R6 reject pulse", 64'(adj_reject), 64'd1);
    check("R6 ns unchanged", 64'(tod_ns), 64'd999_999_300);
    check("R6 sec unchanged", 64'(tod_sec), 64'd10);
    @(negedge clk);
    check("R6 pulse ends", 64'(adj_reject), 64'd0);

    // R4: nanosecond load of 1e9 ignored
    wr(3'd2, 32'd1_000_000_000);
    check("R4 bad load ns", 64'(tod_ns), 64'd999_999_300);
    check("R4 bad load sec", 64'(tod_sec), 64'd10);

    // R8: coherent snapshot
    wr(3'd5, 32'h0080_0000);
    wr(3'd4, 32'd7);
    rd(3'd1, r);
    check("R8 sec lo", 64'(r), 64'd10);
    repeat (6) @(negedge clk);
    rd(3'd2, r); check("R8 snap ns", 64'(r), 64'd999_999_300);
    rd(3'd3, r); check("R8 snap frac", 64'(r), 64'h80_0000);
    rd(3'd0, r); check("R8 snap hi", 64'(r), 64'd0);

    // R9: capture on direction 1
    v_ns = tod_ns; v_sec = tod_sec;
    evt_strobe = 2'b10;
    @(negedge clk);
    evt_strobe = 2'b00;
    check("R9 valid", 64'(cap_valid), 64'b10);
    check("R9 stamp", 64'(cap_stamp[SW +: SW]), 64'({v_sec[4:0], v_ns}));
    check("R9 sec", 64'(cap_sec[48 +: 48]), 64'(v_sec));
    @(negedge clk);
    check("R9 pulse ends", 64'(cap_valid), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule